// File: doc/BRIEF.md
# Dual-Mode Interrupt Vector Dispatcher

This block turns interrupt requests from an address-translation unit into deliveries. Each of its vectors can be delivered in one of two ways. In wired mode a request becomes a one-cycle pulse on that vector's own output line. In message mode the block reads that vector's table entry and issues a single 32-bit write of the entry's data word to the entry's 64-bit target address. One bit in a control register picks the mode for every vector.

Software reaches a small register space through a simple write/read port. The port reaches a capability word, a control word, a vector table and a pending-bit array. Message requests are held in a per-vector pending register. The block sends them lowest vector first, with one memory write outstanding at a time. A masked vector keeps its request pending until it is unmasked. An error response from memory sets a sticky flag and does not stall the requests that follow.

Top module: `irq_msg_dispatch`

## Requirements
- R1: The capability word at offset 0x000 reads 0x3 (bit 0: wired delivery supported, bit 1: message delivery supported). Writes to it have no effect.
- R2: The control word at offset 0x008 resets to 0. Bit 0 selects wired delivery when 1. Bit 1 is the sticky error flag and is cleared by writing 1 to it. Bit 1 is also driven on `err_flag`.
- R3: The vector table starts at offset 0x400 and holds 5 entries of 16 bytes each. Entry v has its target address low word at +16v, address high word at +16v+4, data word at +16v+8 and control word at +16v+12. Every word reads back what was written.
- R4: When `reg_wide` is 1, an access covers two 32-bit words. The word at the given offset goes on bits 31:0 and the word at offset+4 goes on bits 63:32. When `reg_wide` is 0, `reg_rdata[63:32]` is 0.
- R5: The pending array sits at offset 0x500 and is 8 bytes long. Bit v of its first word is the pending flag of vector v. Writes to it are discarded.
- R6: Inside the table and pending windows, offsets past the sized contents read 0 and ignore writes, without disturbing any valid entry.
- R7: With wired delivery selected, a `notify` bit v seen at a clock edge drives `wire_irq[v]` high for exactly the following cycle, and no memory write is issued.
- R8: With message delivery selected, a `notify` on vector v produces exactly one memory write whose address is entry v's 64-bit address and whose data is entry v's data word.
- R9: Message requests waiting on a busy write port are sent in ascending vector order, and none is lost. Repeated requests on a vector that is already pending merge into one write.
- R10: While bit 0 of an entry's control word (the mask) is 1, that vector's message is held and its pending bit stays set. After the mask is cleared the message is sent and the pending bit clears.
- R11: A write response carrying an error sets the sticky error flag. The flag stays set until it is cleared, and later messages are still sent.
- R12: `mem_req_valid` stays high with a stable address and data until `mem_req_ready` accepts it. No new request is raised while a response is still owed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wide | input | 1 | Access covers 8 bytes (two words) |
| reg_addr | input | 12 | Byte offset of the access |
| reg_wdata | input | 64 | Write data, low word at the lower offset |
| reg_rdata | output | 64 | Read data for reg_addr, combinational |
| notify | input | 5 | Per-vector interrupt request, one bit per vector |
| wire_irq | output | 5 | Wired interrupt pulses |
| mem_req_valid | output | 1 | Message write request valid |
| mem_req_ready | input | 1 | Message write request accepted |
| mem_req_addr | output | 64 | Message target address |
| mem_req_data | output | 32 | Message data word |
| mem_rsp_valid | input | 1 | Write response valid |
| mem_rsp_err | input | 1 | Write response carries an error |
| err_flag | output | 1 | Sticky message write error |

## Verification
The hardest situation to reach is when requests pile up behind an outstanding write while a masked vector is pending, because the order in which they drain then depends on all three. The bench sets this up in a few ways. It staggers notifies so that some arrive after a write has been picked. It holds the write port not-ready so that requests collect. It masks a vector and notifies it twice before unmasking it. In each case it compares the sequence of captured memory writes with the expected order and count.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
   typedef enum logic [1:0] {
      ENG_IDLE = 2'd0,
      ENG_REQ  = 2'd1,
      ENG_WAIT = 2'd2
   } eng_state_t;

   localparam int CAP_WIRED_BIT = 0;
   localparam int CAP_MSG_BIT   = 1;
   localparam int WORDS_PER_ENT = 4;
   localparam int ENT_ADDR_LO   = 0;
   localparam int ENT_ADDR_HI   = 1;
   localparam int ENT_DATA      = 2;
   localparam int ENT_CTRL      = 3;
endpackage

// File: rtl/irqd_vec_table.sv
module irqd_vec_table #(
   parameter int NUM_VEC = 5,
   parameter int WPE     = 4,
   parameter int IW      = 5
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           we_a,
   input  logic [IW-1:0]                  idx_a,
   input  logic [31:0]                    data_a,
   input  logic                           we_b,
   input  logic [IW-1:0]                  idx_b,
   input  logic [31:0]                    data_b,
   output logic [NUM_VEC*WPE-1:0][31:0]   words
);
   localparam int NW = NUM_VEC * WPE;

   generate
      if (NW > (1 << IW)) begin : g_bad_iw
         $error("index width too small for table");
      end
      for (genvar w = 0; w < NW; w++) begin : g_word
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               words[w] <= '0;
            else if (we_a && (idx_a == IW'(w)))
               words[w] <= data_a;
            else if (we_b && (idx_b == IW'(w)))
               words[w] <= data_b;
         end
      end
   endgenerate
endmodule

// File: rtl/irqd_pick.sv
module irqd_pick #(
   parameter int N  = 5,
   parameter int VW = 3
) (
   input  logic [N-1:0]  req,
   output logic          found,
   output logic [VW-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            found = 1'b1;
            idx   = VW'(i);
         end
      end
   end
endmodule

// File: rtl/irqd_msg_engine.sv
module irqd_msg_engine
   import irqd_pkg::*;
#(
   parameter int MAW = 64
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           found,
   input  logic [MAW-1:0] ent_addr,
   input  logic [31:0]    ent_data,
   output logic           take,
   output logic           mem_req_valid,
   input  logic           mem_req_ready,
   output logic [MAW-1:0] mem_req_addr,
   output logic [31:0]    mem_req_data,
   input  logic           mem_rsp_valid,
   input  logic           mem_rsp_err,
   output logic           err_set
);
   eng_state_t st_q;

   assign take          = (st_q == ENG_IDLE) && found;
   assign mem_req_valid = (st_q == ENG_REQ);
   assign err_set       = (st_q == ENG_WAIT) && mem_rsp_valid && mem_rsp_err;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q         <= ENG_IDLE;
         mem_req_addr <= '0;
         mem_req_data <= '0;
      end else begin
         unique case (st_q)
            ENG_IDLE: if (found) begin
               mem_req_addr <= ent_addr;
               mem_req_data <= ent_data;
               st_q         <= ENG_REQ;
            end
            ENG_REQ:  if (mem_req_ready) st_q <= ENG_WAIT;
            ENG_WAIT: if (mem_rsp_valid) st_q <= ENG_IDLE;
            default:  st_q <= ENG_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/irq_msg_dispatch.sv
module irq_msg_dispatch
   import irqd_pkg::*;
#(
   parameter int NUM_VEC  = 5,
   parameter int REG_AW   = 12,
   parameter int MAW      = 64,
   parameter int CAP_OFS  = 'h000,
   parameter int CTRL_OFS = 'h008,
   parameter int TBL_BASE = 'h400
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic               reg_wide,
   input  logic [REG_AW-1:0]  reg_addr,
   input  logic [63:0]        reg_wdata,
   output logic [63:0]        reg_rdata,
   input  logic [NUM_VEC-1:0] notify,
   output logic [NUM_VEC-1:0] wire_irq,
   output logic               mem_req_valid,
   input  logic               mem_req_ready,
   output logic [MAW-1:0]     mem_req_addr,
   output logic [31:0]        mem_req_data,
   input  logic               mem_rsp_valid,
   input  logic               mem_rsp_err,
   output logic               err_flag
);
   localparam int NW        = NUM_VEC * WORDS_PER_ENT;
   localparam int IW        = $clog2(NW);
   localparam int VW        = $clog2(NUM_VEC);
   localparam int TBL_BYTES = NW * 4;
   localparam int PBA_BASE  = TBL_BASE + 256;
   localparam int PBA_BITS  = ((NUM_VEC + 63) / 64) * 64;
   localparam int PBA_WORDS = PBA_BITS / 32;
   localparam int PW        = $clog2(PBA_WORDS);
   localparam logic [REG_AW-1:0] CAP_A     = REG_AW'(CAP_OFS);
   localparam logic [REG_AW-1:0] CTRL_A    = REG_AW'(CTRL_OFS);
   localparam logic [REG_AW-1:0] TBL_A     = REG_AW'(TBL_BASE);
   localparam logic [REG_AW-1:0] TBL_END_A = REG_AW'(TBL_BASE + TBL_BYTES);
   localparam logic [REG_AW-1:0] PBA_A     = REG_AW'(PBA_BASE);
   localparam logic [REG_AW-1:0] PBA_END_A = REG_AW'(PBA_BASE + PBA_WORDS * 4);
   localparam logic [31:0] CAP_VALUE =
      (32'd1 << CAP_WIRED_BIT) | (32'd1 << CAP_MSG_BIT);

   generate
      if (NUM_VEC < 2 || NUM_VEC > 64) begin : g_bad_nvec
         $error("NUM_VEC must lie in 2..64");
      end
      if (TBL_BYTES > 256) begin : g_bad_tbl
         $error("vector table overlaps pending window");
      end
      if ((PBA_BASE + PBA_WORDS * 4) > (1 << REG_AW)) begin : g_bad_aw
         $error("register space too small");
      end
      if (CAP_OFS >= TBL_BASE || CTRL_OFS >= TBL_BASE) begin : g_bad_ofs
         $error("control words must sit below the table");
      end
   endgenerate

   logic                         wired_q, err_q;
   logic [NUM_VEC-1:0]           pend_q, wire_q, mask, pend_clr;
   logic [NW-1:0][31:0]          tbl_words;
   logic [PBA_BITS-1:0]          pend_pad;
   logic [REG_AW-1:0]            a_lo, a_hi;
   logic                         we_a, we_b, ctrl_hit, err_clr, err_set;
   logic [IW-1:0]                idx_a, idx_b;
   logic                         found, take;
   logic [VW-1:0]                pick_idx;
   logic [MAW-1:0]               sel_addr;
   logic [31:0]                  sel_data;

   assign a_lo     = {reg_addr[REG_AW-1:2], 2'b00};
   assign a_hi     = a_lo + REG_AW'(4);
   assign pend_pad = PBA_BITS'(pend_q);

   function automatic logic in_tbl(input logic [REG_AW-1:0] a);
      return (a >= TBL_A) && (a < TBL_END_A);
   endfunction

   function automatic logic in_pba(input logic [REG_AW-1:0] a);
      return (a >= PBA_A) && (a < PBA_END_A);
   endfunction

   function automatic logic [IW-1:0] tbl_idx(input logic [REG_AW-1:0] a);
      logic [REG_AW-1:0] off;
      off = (a - TBL_A) >> 2;
      return IW'(off);
   endfunction

   function automatic logic [31:0] rd_word(input logic [REG_AW-1:0] a);
      logic [REG_AW-1:0] op;
      logic [PW-1:0]     k;
      op = (a - PBA_A) >> 2;
      k  = PW'(op);
      if (a == CAP_A)       return CAP_VALUE;
      else if (a == CTRL_A) return {30'd0, err_q, wired_q};
      else if (in_tbl(a))   return tbl_words[tbl_idx(a)];
      else if (in_pba(a))   return pend_pad[32*int'(k) +: 32];
      else                  return 32'd0;
   endfunction

   // register write decode; pending window and capability take no writes
   assign we_a     = reg_wr && in_tbl(a_lo);
   assign idx_a    = tbl_idx(a_lo);
   assign we_b     = reg_wr && reg_wide && in_tbl(a_hi);
   assign idx_b    = tbl_idx(a_hi);
   assign ctrl_hit = reg_wr && (a_lo == CTRL_A);
   assign err_clr  = ctrl_hit && reg_wdata[1];

   always_comb begin
      reg_rdata[31:0]  = rd_word(a_lo);
      reg_rdata[63:32] = reg_wide ? rd_word(a_hi) : 32'd0;
   end

   irqd_vec_table #(
      .NUM_VEC (NUM_VEC),
      .WPE     (WORDS_PER_ENT),
      .IW      (IW)
   ) u_table (
      .clk    (clk),
      .rst_n  (rst_n),
      .we_a   (we_a),
      .idx_a  (idx_a),
      .data_a (reg_wdata[31:0]),
      .we_b   (we_b),
      .idx_b  (idx_b),
      .data_b (reg_wdata[63:32]),
      .words  (tbl_words)
   );

   generate
      for (genvar v = 0; v < NUM_VEC; v++) begin : g_mask
         assign mask[v] = tbl_words[v*WORDS_PER_ENT + ENT_CTRL][0];
      end
   endgenerate

   irqd_pick #(
      .N  (NUM_VEC),
      .VW (VW)
   ) u_pick (
      .req   (pend_q & ~mask),
      .found (found),
      .idx   (pick_idx)
   );

   always_comb begin
      sel_addr = {tbl_words[int'(pick_idx)*WORDS_PER_ENT + ENT_ADDR_HI],
                  tbl_words[int'(pick_idx)*WORDS_PER_ENT + ENT_ADDR_LO]};
      sel_data = tbl_words[int'(pick_idx)*WORDS_PER_ENT + ENT_DATA];
   end

   irqd_msg_engine #(
      .MAW (MAW)
   ) u_engine (
      .clk           (clk),
      .rst_n         (rst_n),
      .found         (found),
      .ent_addr      (sel_addr),
      .ent_data      (sel_data),
      .take          (take),
      .mem_req_valid (mem_req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_req_addr  (mem_req_addr),
      .mem_req_data  (mem_req_data),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_err   (mem_rsp_err),
      .err_set       (err_set)
   );

   assign pend_clr = take ? (NUM_VEC'(1) << pick_idx) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wired_q <= 1'b0;
         err_q   <= 1'b0;
         pend_q  <= '0;
         wire_q  <= '0;
      end else begin
         if (ctrl_hit) wired_q <= reg_wdata[0];
         // a fresh error wins over a clear in the same cycle
         err_q  <= (err_q && !err_clr) || err_set;
         pend_q <= (pend_q & ~pend_clr) | (notify & {NUM_VEC{~wired_q}});
         wire_q <= notify & {NUM_VEC{wired_q}};
      end
   end

   assign wire_irq = wire_q;
   assign err_flag = err_q;
endmodule

// File: rtl/irqd_chk.sv
module irqd_chk #(
   parameter int NUM_VEC = 5,
   parameter int MAW     = 64
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_VEC-1:0] notify,
   input logic [NUM_VEC-1:0] wire_irq,
   input logic               wired_sel,
   input logic               mem_req_valid,
   input logic               mem_req_ready,
   input logic [MAW-1:0]     mem_req_addr,
   input logic [31:0]        mem_req_data,
   input logic               mem_rsp_valid,
   input logic               mem_rsp_err,
   input logic               err_clr,
   input logic               err_flag
);
   logic outst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         outst <= 1'b0;
      else if (mem_req_valid && mem_req_ready)
         outst <= 1'b1;
      else if (mem_rsp_valid)
         outst <= 1'b0;
   end

   assert_pulse_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wire_irq != '0) |-> (((wire_irq & ~$past(notify)) == '0) && $past(wired_sel)));

   assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=>
         (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_data)));

   assert_one_outstanding_R12: assert property (@(posedge clk) disable iff (!rst_n)
      outst |-> !mem_req_valid);

   assert_err_capture_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (outst && mem_rsp_valid && mem_rsp_err) |=> err_flag);

   assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (err_flag && !err_clr) |=> err_flag);
endmodule

bind irq_msg_dispatch irqd_chk #(
   .NUM_VEC (NUM_VEC),
   .MAW     (MAW)
) u_irqd_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .notify        (notify),
   .wire_irq      (wire_irq),
   .wired_sel     (wired_q),
   .mem_req_valid (mem_req_valid),
   .mem_req_ready (mem_req_ready),
   .mem_req_addr  (mem_req_addr),
   .mem_req_data  (mem_req_data),
   .mem_rsp_valid (mem_rsp_valid),
   .mem_rsp_err   (mem_rsp_err),
   .err_clr       (err_clr),
   .err_flag      (err_flag)
);

// File: tb/tb_irq_msg_dispatch.sv
module tb_irq_msg_dispatch;
   localparam int CLK_PERIOD = 10;
   localparam int NV   = 5;
   localparam int TBL  = 'h400;
   localparam int PBA  = 'h500;
   localparam int CTRL = 'h008;
   localparam int CAP  = 'h000;
   // stimulus vectors: {target address, data word} per entry
   localparam logic [95:0] STIM [NV] = '{
      {64'h0000_0001_2000_0000, 32'hA000_0000},
      {64'h0000_0000_FEE0_1004, 32'hB111_0001},
      {64'h8000_0000_0000_0010, 32'hC222_0002},
      {64'h0000_00FF_1234_5678, 32'hD333_0003},
      {64'h1111_2222_3333_4440, 32'hE444_0004}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic reg_wr = 1'b0, reg_wide = 1'b0;
   logic [11:0] reg_addr = '0;
   logic [63:0] reg_wdata = '0, reg_rdata;
   logic [NV-1:0] notify = '0, wire_irq;
   logic mem_req_valid, mem_req_ready = 1'b1;
   logic [63:0] mem_req_addr;
   logic [31:0] mem_req_data;
   logic mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0, err_flag;
   logic err_next = 1'b0;

   int n_chk = 0, n_fail = 0, log_n = 0;
   logic [63:0] log_addr [64];
   logic [31:0] log_data [64];
   logic [63:0] rd;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_msg_dispatch dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wide(reg_wide),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .notify(notify), .wire_irq(wire_irq), .mem_req_valid(mem_req_valid),
      .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
      .mem_req_data(mem_req_data), .mem_rsp_valid(mem_rsp_valid),
      .mem_rsp_err(mem_rsp_err), .err_flag(err_flag)
   );

   // memory responder: logs each accepted write, answers two cycles later
   initial begin
      forever begin
         @(negedge clk); #1;
         mem_rsp_valid = 1'b0;
         if (mem_req_valid && mem_req_ready) begin
            if (log_n < 64) begin
               log_addr[log_n] = mem_req_addr;
               log_data[log_n] = mem_req_data;
            end
            log_n++;
            @(negedge clk);
            @(negedge clk); #1;
            mem_rsp_valid = 1'b1;
            mem_rsp_err   = err_next;
         end
      end
   end

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [63:0] d, input logic wide);
      @(negedge clk);
      reg_addr = 12'(a); reg_wdata = d; reg_wide = wide; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; reg_wide = 1'b0;
   endtask

   task automatic rdr(input int a, input logic wide, output logic [63:0] d);
      @(negedge clk);
      reg_addr = 12'(a); reg_wide = wide;
      #1 d = reg_rdata;
      reg_wide = 1'b0;
   endtask

   task automatic pulse(input logic [NV-1:0] v);
      @(negedge clk);
      notify = v;
      @(negedge clk);
      notify = '0;
   endtask

   task automatic wait_log(input int n);
      for (int t = 0; t < 300 && log_n < n; t++) @(negedge clk);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      summary();
      $finish;
   end

   initial begin
      int base;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      chk("R7 reset wire_irq", 64'(wire_irq), 64'h0);
      chk("R12 reset req", 64'(mem_req_valid), 64'h0);
      chk("R2 reset err_flag", 64'(err_flag), 64'h0);
      rdr(CTRL, 1'b0, rd); chk("R2 ctrl reset", rd, 64'h0);
      rdr(CAP, 1'b0, rd);  chk("R1 capability", rd, 64'h3);
      wr(CAP, 64'h0, 1'b0);
      rdr(CAP, 1'b0, rd);  chk("R1 capability write ignored", rd, 64'h3);

      // table-driven loop: program, read back, message per entry
      for (int i = 0; i < NV; i++) begin
         wr(TBL + 16*i, STIM[i][95:32], 1'b1);
         wr(TBL + 16*i + 8, {32'h0, STIM[i][31:0]}, 1'b0);
         rdr(TBL + 16*i, 1'b1, rd);
         chk("R3 R4 address readback", rd, STIM[i][95:32]);
         rdr(TBL + 16*i + 8, 1'b0, rd);
         chk("R3 R4 data readback narrow", rd, {32'h0, STIM[i][31:0]});
         base = log_n;
         pulse(NV'(1) << i);
         wait_log(base + 1);
         chk("R8 message count", 64'(log_n), 64'(base + 1));
         chk("R8 message address", log_addr[base], STIM[i][95:32]);
         chk("R8 message data", 64'(log_data[base]), 64'(STIM[i][31:0]));
         idle(4);
      end

      // wired mode: pulse for one cycle, no message
      wr(CTRL, 64'h1, 1'b0);
      base = log_n;
      @(negedge clk); notify = 5'b00100;
      @(negedge clk); notify = '0;
      chk("R7 wired pulse", 64'(wire_irq), 64'h4);
      @(negedge clk);
      chk("R7 pulse one cycle", 64'(wire_irq), 64'h0);
      idle(8);
      chk("R7 no message in wired mode", 64'(log_n), 64'(base));
      wr(CTRL, 64'h0, 1'b0);

      // simultaneous requests drain in ascending order
      base = log_n;
      pulse(5'b11010);
      wait_log(base + 3);
      chk("R9 order first", 64'(log_data[base]), 64'(STIM[1][31:0]));
      chk("R9 order second", 64'(log_data[base+1]), 64'(STIM[3][31:0]));
      chk("R9 order third", 64'(log_data[base+2]), 64'(STIM[4][31:0]));
      idle(6);

      // requests arriving while a write is picked
      base = log_n;
      @(negedge clk); notify = 5'b10000;
      @(negedge clk); notify = 5'b00101;
      @(negedge clk); notify = '0;
      wait_log(base + 3);
      idle(6);
      chk("R9 staggered count", 64'(log_n), 64'(base + 3));
      chk("R9 staggered first", 64'(log_data[base]), 64'(STIM[4][31:0]));
      chk("R9 staggered second", 64'(log_data[base+1]), 64'(STIM[0][31:0]));
      chk("R9 staggered third", 64'(log_data[base+2]), 64'(STIM[2][31:0]));

      // stalled write port holds the request steady
      mem_req_ready = 1'b0;
      base = log_n;
      pulse(5'b01000);
      idle(4);
      chk("R12 valid held", 64'(mem_req_valid), 64'h1);
      chk("R12 address held", mem_req_addr, STIM[3][95:32]);
      chk("R12 nothing accepted", 64'(log_n), 64'(base));
      mem_req_ready = 1'b1;
      wait_log(base + 1);
      chk("R12 accepted once ready", 64'(log_data[base]), 64'(STIM[3][31:0]));
      idle(6);

      // masked vector holds, merges, then sends on unmask
      wr(TBL + 12, 64'h1, 1'b0);
      base = log_n;
      pulse(5'b00001);
      idle(2);
      pulse(5'b00001);
      idle(8);
      chk("R10 masked no message", 64'(log_n), 64'(base));
      rdr(PBA, 1'b0, rd); chk("R10 pending set", rd, 64'h1);
      wr(PBA, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
      rdr(PBA, 1'b1, rd); chk("R5 pending write discarded", rd, 64'h1);
      wr(TBL + 12, 64'h0, 1'b0);
      wait_log(base + 1);
      idle(10);
      chk("R10 R9 one merged message", 64'(log_n), 64'(base + 1));
      chk("R10 unmasked data", 64'(log_data[base]), 64'(STIM[0][31:0]));
      rdr(PBA, 1'b0, rd); chk("R10 pending cleared", rd, 64'h0);

      // out-of-range words inside the windows
      rdr(TBL + 16*NV, 1'b0, rd); chk("R6 past table reads zero", rd, 64'h0);
      wr(TBL + 16*NV, 64'hDEAD_BEEF, 1'b0);
      rdr(TBL + 16*NV, 1'b0, rd); chk("R6 past table write ignored", rd, 64'h0);
      rdr(TBL + 16*(NV-1) + 8, 1'b0, rd);
      chk("R6 last entry intact", rd, {32'h0, STIM[NV-1][31:0]});
      rdr(TBL + 16*(NV-1) + 12, 1'b1, rd);
      chk("R4 R6 wide read upper half zero", rd, 64'h0);
      rdr(PBA + 8, 1'b0, rd); chk("R6 past pending reads zero", rd, 64'h0);

      // error response: sticky, does not block
      err_next = 1'b1;
      base = log_n;
      pulse(5'b00010);
      wait_log(base + 1);
      idle(5);
      err_next = 1'b0;
      chk("R11 err_flag set", 64'(err_flag), 64'h1);
      rdr(CTRL, 1'b0, rd); chk("R2 R11 ctrl error bit", rd, 64'h2);
      pulse(5'b00100);
      wait_log(base + 2);
      chk("R11 later message sent", 64'(log_data[base+1]), 64'(STIM[2][31:0]));
      idle(5);
      chk("R11 flag stays set", 64'(err_flag), 64'h1);
      wr(CTRL, 64'h2, 1'b0);
      chk("R2 error cleared by write one", 64'(err_flag), 64'h0);

      summary();
      $finish;
   end
endmodule